// File: doc/BRIEF.md
# FIFO Block-Transfer Interrupt Decision

This block decides when a serial port raises its interrupt request from the fill state of its transmit and receive FIFOs. It has two behaviours. In per-character operation, each character that is received or transmitted latches a pending request. The request stays up until the host services that direction. In block-transfer (DMA) operation, the request follows a level comparison on one selected direction. For transmit, it is raised while the transmit FIFO holds fewer entries than its trigger threshold. For receive, it is raised while the receive FIFO holds more entries than its threshold.

The block also produces two line-status flags: one says the transmitter still has room, and the other says the transmitter FIFO is completely drained. The FIFO storage, the register decode and the serial shift engines sit outside the block. They supply the fill counts, the control bits, and one-cycle strobes for characters arriving, characters leaving the shifter, host reads and host writes.

Top module: `fifo_dma_irq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `irq`=0, `tx_space`=1 and `tx_empty`=1.
- R2: In per-character operation, an `rx_char` strobe makes `irq` high from the next cycle. It stays high until an `rx_pop` strobe without a coinciding `rx_char`; `irq` then drops one cycle after that pop, provided no transmit request is pending.
- R3: In per-character operation, a `tx_char` strobe makes `irq` high from the next cycle. It stays high until a `tx_push` strobe without a coinciding `tx_char`; `irq` then drops one cycle after that push, provided no receive request is pending.
- R4: When a character strobe and the servicing strobe of the same direction occur in the same cycle, the request stays pending.
- R5: Per-character operation applies whenever `fifo_en`=0, whatever the value of `dma_mode`. It also applies when `fifo_en`=1 and `dma_mode`=0.
- R6: Block-transfer operation applies when `fifo_en`=1 and `dma_mode`=1. With `dma_dir`=1 (receive), `irq` is 1 exactly when `rx_count` is strictly greater than the receive threshold, and the transmit count has no effect.
- R7: In block-transfer operation with `dma_dir`=0 (transmit), `irq` is 1 exactly when `tx_count` is strictly less than the transmit threshold, and the receive count has no effect.
- R8: A 2-bit trigger select maps to a threshold as follows: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2 and 3 gives DEPTH-2. For the default DEPTH of 16 these are 1, 4, 8 and 14.
- R9: During block-transfer operation, per-character pending requests are cleared and character strobes are ignored. After a return to per-character operation, `irq` stays 0 until a new character strobe arrives.
- R10: `tx_space` is 1 exactly when `tx_count` < DEPTH, and `tx_empty` is 1 exactly when `tx_count` is 0. Counts never exceed DEPTH.
- R11: All three outputs are registered, and each reflects the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | Block-transfer operation select |
| dma_dir | input | 1 | Block-transfer direction: 0 transmit, 1 receive |
| tx_trig_sel | input | 2 | Transmit trigger select |
| rx_trig_sel | input | 2 | Receive trigger select |
| tx_count | input | CNT_W (5) | Transmit FIFO fill count |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| rx_char | input | 1 | Strobe: a character entered the receive path |
| rx_pop | input | 1 | Strobe: host read a received character |
| tx_char | input | 1 | Strobe: a character left the transmitter |
| tx_push | input | 1 | Strobe: host wrote a transmit character |
| irq | output | 1 | Interrupt request |
| tx_space | output | 1 | Transmit FIFO has at least one free entry |
| tx_empty | output | 1 | Transmit FIFO fully empty |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. This covers the level comparisons, the pending-request updates and the status flags, because the pending state and the output flops are updated on the same edge. The bench drives inputs on the falling edge. Its reference model advances once per rising edge from those inputs, and it compares all three outputs on the following falling edge. As a result, a result that arrives one cycle late or one cycle early shows up as a mismatch in that very cycle. The directed phases line up strobes, same-cycle set/clear pairs, mode switches and threshold boundaries. A random phase then mixes all inputs.

// File: rtl/fdi_pkg.sv
// Package fdi_pkg
// Shared types and helpers for the FIFO interrupt decision block.
// Assumes FIFO depth is a multiple of 4 and at least 4.
package fdi_pkg;

    // Block-transfer direction encoding
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dma_dir_e;

    // Index of each per-character request channel
    localparam int CH_RX = 0;
    localparam int CH_TX = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/fdi_trig_decode.sv
// Module fdi_trig_decode
// Turns a 2-bit trigger select into a fill threshold.
// Mapping: 0 -> 1, 1 -> DEPTH/4, 2 -> DEPTH/2, 3 -> DEPTH-2.
// Purely combinational; assumes DEPTH >= 4.
module fdi_trig_decode #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] thr
);
    localparam logic [CNT_W-1:0] THR_0 = CNT_W'(1);
    localparam logic [CNT_W-1:0] THR_1 = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] THR_2 = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] THR_3 = CNT_W'(DEPTH - 2);

    // Select the threshold for the current code
    always_comb begin
        unique case (sel)
            2'd0:    thr = THR_0;
            2'd1:    thr = THR_1;
            2'd2:    thr = THR_2;
            default: thr = THR_3;
        endcase
    end
endmodule

// File: rtl/fdi_level_cmp.sv
// Module fdi_level_cmp
// Block-transfer request. In the transmit direction it requests while the
// transmit count is strictly below its threshold. In the receive direction
// it requests while the receive count is strictly above its threshold.
// Combinational; the caller registers the result.
module fdi_level_cmp #(
    parameter int CNT_W = 5
) (
    input  logic             dir_rx,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic [CNT_W-1:0] rx_thr,
    output logic             level_req
);
    import fdi_pkg::*;

    dma_dir_e dir;

    // Map the raw direction bit onto the enum
    always_comb dir = dir_rx ? DIR_RX : DIR_TX;

    // Compare the selected direction against its threshold
    always_comb begin
        if (dir == DIR_RX) level_req = (rx_count > rx_thr);
        else               level_req = (tx_count < tx_thr);
    end
endmodule

// File: rtl/fdi_char_pending.sv
// Module fdi_char_pending
// Per-character request flags, one per channel (receive, transmit).
// A character strobe sets its flag and the host service strobe clears it.
// Set wins when both arrive together, and clr_all empties every flag.
// The next-state value is exported so the top can register the interrupt
// in the same edge as the flag update.
module fdi_char_pending #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_all,
    input  logic [NCH-1:0] set_ev,
    input  logic [NCH-1:0] svc_ev,
    output logic [NCH-1:0] pend_nxt,
    output logic [NCH-1:0] pend_q
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Next state: cleared by mode, else set beats service
        always_comb begin
            if (clr_all)        pend_nxt[c] = 1'b0;
            else if (set_ev[c]) pend_nxt[c] = 1'b1;
            else if (svc_ev[c]) pend_nxt[c] = 1'b0;
            else                pend_nxt[c] = pend_q[c];
        end

        // Hold the flag
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[c] <= 1'b0;
            else        pend_q[c] <= pend_nxt[c];
        end

        // A strobe outside block-transfer mode always leaves the flag set (R2, R3, R4)
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_ev[c] && !clr_all) |=> pend_q[c]);

        // Service without a new strobe drops the flag (R2, R3)
        assert_service_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (svc_ev[c] && !set_ev[c]) |=> !pend_q[c]);

        // Block-transfer mode wipes the flag (R9)
        assert_mode_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all |=> !pend_q[c]);
    end
endmodule

// File: rtl/fifo_dma_irq.sv
// Module fifo_dma_irq (top)
// Interrupt decision from FIFO occupancy, plus transmitter line-status flags.
// Per-character operation (FIFOs disabled, or DMA mode off) latches a
// request per received or transmitted character until the host services it.
// Block-transfer operation compares one selected FIFO count with its
// trigger threshold. All outputs are registered with one cycle of latency.
// Assumes the fill counts never exceed DEPTH and the strobes are one cycle wide.
module fifo_dma_irq #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic             dma_dir,
    input  logic [1:0]       tx_trig_sel,
    input  logic [1:0]       rx_trig_sel,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_char,
    input  logic             rx_pop,
    input  logic             tx_char,
    input  logic             tx_push,
    output logic             irq,
    output logic             tx_space,
    output logic             tx_empty
);
    import fdi_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0]  tx_thr, rx_thr;
    logic              level_req;
    logic              block_mode;
    logic [NUM_CH-1:0] set_ev, svc_ev, pend_nxt, pend_q;
    logic              irq_q, space_q, empty_q;

    // Block-transfer operation needs both FIFO enable and DMA mode
    always_comb block_mode = fifo_en && dma_mode;

    // Gather per-channel strobes into vectors
    always_comb begin
        set_ev         = '0;
        svc_ev         = '0;
        set_ev[CH_RX]  = rx_char;
        svc_ev[CH_RX]  = rx_pop;
        set_ev[CH_TX]  = tx_char;
        svc_ev[CH_TX]  = tx_push;
    end

    fdi_trig_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_trig (
        .sel (tx_trig_sel),
        .thr (tx_thr)
    );

    fdi_trig_decode #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_trig (
        .sel (rx_trig_sel),
        .thr (rx_thr)
    );

    fdi_level_cmp #(.CNT_W(CNT_W)) u_level (
        .dir_rx    (dma_dir),
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .tx_thr    (tx_thr),
        .rx_thr    (rx_thr),
        .level_req (level_req)
    );

    fdi_char_pending #(.NCH(NUM_CH)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (block_mode),
        .set_ev   (set_ev),
        .svc_ev   (svc_ev),
        .pend_nxt (pend_nxt),
        .pend_q   (pend_q)
    );

    // Register the interrupt and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            space_q <= 1'b1;
            empty_q <= 1'b1;
        end else begin
            irq_q   <= block_mode ? level_req : (|pend_nxt);
            space_q <= (tx_count < FULL_CNT);
            empty_q <= (tx_count == '0);
        end
    end

    assign irq      = irq_q;
    assign tx_space = space_q;
    assign tx_empty = empty_q;

    // An empty transmitter always has space (R10)
    assert_empty_has_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_space);

    // Fill counts stay within the FIFO depth (R10)
    assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= FULL_CNT) && (rx_count <= FULL_CNT));

    // Receive level above threshold in block mode raises irq (R6)
    assert_rx_level_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (block_mode && dma_dir && (rx_count > rx_thr)) |=> irq);

    // Transmit level at or above threshold in block mode keeps irq low (R7)
    assert_tx_level_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (block_mode && !dma_dir && (tx_count >= tx_thr)) |=> !irq);

    // Per-character mode: pending request shows on irq (R2, R3)
    assert_pend_drives_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!block_mode && (rx_char || tx_char)) |=> irq);
endmodule

// File: tb/fifo_dma_irq_tb_top.sv
// Bench for fifo_dma_irq: behavioural reference model stepped each clock.
module fifo_dma_irq_tb_top;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fifo_en, dma_mode, dma_dir;
    logic [1:0]    tx_trig_sel, rx_trig_sel;
    logic [CW-1:0] tx_count, rx_count;
    logic          rx_char, rx_pop, tx_char, tx_push;
    logic          irq, tx_space, tx_empty;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state
    bit m_rxp = 0, m_txp = 0;
    bit e_irq = 0, e_space = 1, e_empty = 1;

    always #4 clk = ~clk;

    fifo_dma_irq #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .dma_dir(dma_dir), .tx_trig_sel(tx_trig_sel), .rx_trig_sel(rx_trig_sel),
        .tx_count(tx_count), .rx_count(rx_count), .rx_char(rx_char),
        .rx_pop(rx_pop), .tx_char(tx_char), .tx_push(tx_push),
        .irq(irq), .tx_space(tx_space), .tx_empty(tx_empty)
    );

    // Threshold from requirement R8
    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return DEPTH / 4;
            2'd2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    // Advance the model on the inputs currently applied
    task automatic model_step();
        bit blk;
        if (!rst_n) begin
            m_rxp = 0; m_txp = 0; e_irq = 0; e_space = 1; e_empty = 1;
            return;
        end
        blk = fifo_en && dma_mode;
        if (blk) begin
            m_rxp = 0; m_txp = 0;
        end else begin
            if (rx_char) m_rxp = 1; else if (rx_pop) m_rxp = 0;
            if (tx_char) m_txp = 1; else if (tx_push) m_txp = 0;
        end
        if (blk) e_irq = dma_dir ? (int'(rx_count) > thr_of(rx_trig_sel))
                                 : (int'(tx_count) < thr_of(tx_trig_sel));
        else     e_irq = m_rxp || m_txp;
        e_space = int'(tx_count) < DEPTH;
        e_empty = tx_count == 0;
    endtask

    // One clock: model follows the edge, compare at the next falling edge
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        n_cmp++;
        if (irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b t=%0t", tag, irq, e_irq, $time);
        end
        n_cmp++;
        if (tx_space !== e_space) begin
            n_bad++;
            $display("FAIL %s tx_space actual=%0b expected=%0b", tag, tx_space, e_space);
        end
        n_cmp++;
        if (tx_empty !== e_empty) begin
            n_bad++;
            $display("FAIL %s tx_empty actual=%0b expected=%0b", tag, tx_empty, e_empty);
        end
        rx_char = 0; rx_pop = 0; tx_char = 0; tx_push = 0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; fifo_en = 0; dma_mode = 0; dma_dir = 0;
        tx_trig_sel = 0; rx_trig_sel = 0; tx_count = 5; rx_count = 3;
        rx_char = 1; rx_pop = 0; tx_char = 1; tx_push = 0;
        @(negedge clk);
        cycle("R1 reset");
        cycle("R1 reset");
        rst_n = 1;
        tx_count = 0; rx_count = 0;
        idle(2, "R1 idle");

        // R2 receive character pending until pop
        fifo_en = 1; dma_mode = 0;
        rx_char = 1; cycle("R2 rx set");
        idle(3, "R2 hold");
        rx_pop = 1; cycle("R2 pop");
        idle(2, "R2 low");

        // R3 transmit character pending until push
        tx_char = 1; cycle("R3 tx set");
        idle(2, "R3 hold");
        rx_pop = 1; cycle("R3 wrong service");
        tx_push = 1; cycle("R3 push");
        idle(1, "R3 low");

        // R4 same-cycle set and service
        rx_char = 1; rx_pop = 1; cycle("R4 rx both");
        idle(1, "R4 hold");
        rx_pop = 1; cycle("R4 clear");
        tx_char = 1; tx_push = 1; cycle("R4 tx both");
        tx_push = 1; cycle("R4 clear tx");

        // R5 FIFOs disabled keeps per-character behaviour even with dma_mode
        fifo_en = 0; dma_mode = 1; dma_dir = 1; rx_count = 16;
        idle(1, "R5 no level irq");
        rx_char = 1; cycle("R5 rx set");
        idle(1, "R5 hold");

        // R9 entering block mode clears pending, strobes ignored
        fifo_en = 1; dma_dir = 1; rx_count = 0; rx_trig_sel = 0;
        cycle("R9 enter");
        rx_char = 1; tx_char = 1; cycle("R9 ignore");
        dma_mode = 0; idle(2, "R9 back stays low");

        // R6 receive level, strict greater, all thresholds (R8)
        dma_mode = 1; dma_dir = 1;
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            rx_count = CW'(thr_of(2'(s)));     cycle("R8 rx at thr");
            rx_count = CW'(thr_of(2'(s)) + 1); cycle("R8 rx above");
            tx_count = 0;                      cycle("R6 tx ignored");
        end
        rx_count = 16; cycle("R6 full");

        // R7 transmit level, strict less
        dma_dir = 0; rx_count = 16;
        for (int s = 0; s < 4; s++) begin
            tx_trig_sel = 2'(s);
            tx_count = CW'(thr_of(2'(s)));     cycle("R7 tx at thr");
            tx_count = CW'(thr_of(2'(s)) - 1); cycle("R7 tx below");
        end

        // R10 status flags at boundaries
        tx_count = 16; cycle("R10 full");
        tx_count = 15; cycle("R10 one free");
        tx_count = 0;  cycle("R10 empty");
        tx_count = 1;  cycle("R10 one used");

        // R11 random mix, one-cycle latency on every output
        for (int i = 0; i < 3000; i++) begin
            fifo_en  = 1'($urandom_range(0, 1));
            dma_mode = 1'($urandom_range(0, 1));
            dma_dir  = 1'($urandom_range(0, 1));
            tx_trig_sel = 2'($urandom_range(0, 3));
            rx_trig_sel = 2'($urandom_range(0, 3));
            tx_count = CW'($urandom_range(0, DEPTH));
            rx_count = CW'($urandom_range(0, DEPTH));
            rx_char = 1'($urandom_range(0, 3) == 0);
            rx_pop  = 1'($urandom_range(0, 3) == 0);
            tx_char = 1'($urandom_range(0, 3) == 0);
            tx_push = 1'($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 200) == 0) rst_n = 0; else rst_n = 1;
            cycle("R11 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule